// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block sits next to a 16550-style UART and drives the line-driver enable of a half-duplex RS-485 transceiver without software involvement. It watches two transmitter status signals: whether the serializer is shifting a character, and whether characters are still waiting to be sent. From these it forms a direction signal. The signal is active from the first cycle of the start bit until the last stop bit of the final queued character has been sent. There is no programmable lead or trail time: both turnaround gaps are zero.

A byte-wide configuration register in the port's register window turns the feature on. It also chooses which of two modem-control output pins carries the direction signal, and whether that signal is active high or active low. The pin that is not chosen, and both pins whenever the feature is off, carry the ordinary modem-control values supplied by the UART. Software switches the feature off completely by writing zero to the register.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) clears the configuration register to 0, so both pins carry their modem-control inputs and the register reads back 0.
- R2: A write with cfg_addr equal to CFG_OFFSET (default 0x40) stores write-data bits [2:0] at the next clock edge. Bit 0 is enable, bit 1 is pin select and bit 2 is polarity. A read at that address returns the stored bits with bits [7:3] as 0. A write to any other address leaves the register unchanged, and a read at any other address returns 0.
- R3: When enabled, the selected pin turns active in the same cycle that tx_busy rises. There is no lead delay.
- R4: When enabled, the direction stays active while tx_busy is high or txq_empty is low. It goes inactive in the first cycle where tx_busy is low and txq_empty is high. There is no trail delay.
- R5: With polarity 0 the selected pin is 1 while active and 0 while inactive. With polarity 1 it is 0 while active and 1 while inactive.
- R6: Pin select 1 routes the direction to rts_o and pin select 0 routes it to dtr_o. The pin that is not selected always equals its modem-control input.
- R7: With enable 0, rts_o equals mcr_rts and dtr_o equals mcr_dtr, whatever the transmitter status.
- R8: Writing 0 to the register disables the feature from the next clock edge onward, even in the middle of a transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data, combinational from cfg_addr |
| tx_busy | input | 1 | Serializer is sending a start, data, parity or stop bit |
| txq_empty | input | 1 | No character is waiting to be sent |
| mcr_rts | input | 1 | Ordinary modem-control value for the RTS pin |
| mcr_dtr | input | 1 | Ordinary modem-control value for the DTR pin |
| rts_o | output | 1 | RTS pin output |
| dtr_o | output | 1 | DTR pin output |

## Verification
The pin outputs are combinational from tx_busy, txq_empty and the modem-control inputs. The bench drives these on the falling edge and samples the pins 1 ns later, in the same cycle, which is where the zero-lead and zero-trail requirements place the change. A configuration write takes effect at the first rising edge after the strobe, so every check that depends on a new configuration value is made only after that edge. This applies to the write-zero disable during transmission and to the read-back checks.

// File: rtl/rs485_dir_pkg.sv
// Package: shared configuration layout for the RS-485 direction controller.
// Assumes the configuration fields sit in the low bits of the register byte.
package rs485_dir_pkg;
    // Field order sets the bit positions: pol = bit 2, sel = bit 1, en = bit 0.
    typedef struct packed {
        logic pol;   // 1: pin low while transmitting
        logic sel;   // 1: RTS pin carries direction, 0: DTR pin
        logic en;    // automatic direction control on
    } dir_cfg_t;

    localparam int CFG_W    = $bits(dir_cfg_t);
    localparam int NUM_PINS = 2;   // index 0 = DTR, index 1 = RTS
endpackage

// File: rtl/rs485_cfg_reg.sv
// Module: configuration register for direction control.
// Holds the enable, select and polarity bits. Writes land on the clock edge,
// and reads are combinational. Assumes DATA_W >= CFG_W.
module rs485_cfg_reg
    import rs485_dir_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output dir_cfg_t          cfg
);
    localparam int PAD_W = DATA_W - CFG_W;

    logic hit;
    logic unused_wbits;

    assign hit          = (addr == OFFSET);
    assign unused_wbits = ^wdata[DATA_W-1:CFG_W];

    // Store the low write-data bits on an addressed write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we && hit) begin
            cfg <= dir_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    // Return the stored fields zero-extended when addressed, else zero.
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata = {{PAD_W{1'b0}}, cfg};
        end
    end
endmodule

// File: rtl/rs485_dir_detect.sv
// Module: transmit activity detector.
// Forms the direction level from the transmitter status with no delay.
// Assumes tx_busy covers start through last stop bit, and txq_empty is high
// only when no further character is waiting to be sent.
module rs485_dir_detect
    import rs485_dir_pkg::*;
(
    input  logic     tx_busy,
    input  logic     txq_empty,
    input  dir_cfg_t cfg,
    output logic     active,
    output logic     level
);
    // Active while a character is shifting or another is queued behind it.
    always_comb begin
        active = tx_busy | ~txq_empty;
        level  = active ^ cfg.pol;
    end
endmodule

// File: rtl/rs485_pin_mux.sv
// Module: per-pin output steering.
// Each pin takes the direction level when the feature is on and the pin is
// the selected one; otherwise it passes its modem-control value through.
// Assumes pin index 1 is RTS (select = 1) and index 0 is DTR (select = 0).
module rs485_pin_mux
    import rs485_dir_pkg::*;
(
    input  dir_cfg_t              cfg,
    input  logic                  level,
    input  logic [NUM_PINS-1:0]   mcr,
    output logic [NUM_PINS-1:0]   pin
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic chosen;
        // Decide whether this pin carries direction, then drive it.
        always_comb begin
            chosen = cfg.en && (cfg.sel == 1'(i));
            pin[i] = chosen ? level : mcr[i];
        end
    end
endmodule

// File: rtl/rs485_dir_ctrl.sv
// Module: top of the RS-485 transmit direction controller.
// Joins the configuration register, the activity detector and the pin
// steering. Assumes the status inputs are synchronous to clk.
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              tx_busy,
    input  logic              txq_empty,
    input  logic              mcr_rts,
    input  logic              mcr_dtr,
    output logic              rts_o,
    output logic              dtr_o
);
    dir_cfg_t            cfg_q;
    logic                dir_active;
    logic                dir_level;
    logic [NUM_PINS-1:0] pins;

    rs485_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(CFG_OFFSET)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg_q)
    );

    rs485_dir_detect u_det (
        .tx_busy   (tx_busy),
        .txq_empty (txq_empty),
        .cfg       (cfg_q),
        .active    (dir_active),
        .level     (dir_level)
    );

    rs485_pin_mux u_mux (
        .cfg   (cfg_q),
        .level (dir_level),
        .mcr   ({mcr_rts, mcr_dtr}),
        .pin   (pins)
    );

    assign rts_o = pins[1];
    assign dtr_o = pins[0];
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
// Module: assertion checker for rs485_dir_ctrl, attached by bind.
// Observes ports and the stored configuration bits.
module rs485_dir_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              tx_busy,
    input logic              txq_empty,
    input logic              mcr_rts,
    input logic              mcr_dtr,
    input logic              rts_o,
    input logic              dtr_o,
    input logic [2:0]        cfg_bits
);
    // Reset leaves the register cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> cfg_bits == 3'b000);

    // Selected RTS, active-high: busy drives the pin high in that cycle.
    p_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits == 3'b011 && tx_busy) |-> rts_o);

    // Selected RTS, active-high: idle with empty queue drops the pin.
    p_trail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits == 3'b011 && !tx_busy && txq_empty) |-> !rts_o);

    // Active-low polarity on RTS during transmission.
    p_low_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits == 3'b111 && tx_busy) |-> !rts_o);

    // The pin that is not selected follows its modem-control input.
    p_unsel_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[0] && cfg_bits[1]) |-> dtr_o == mcr_dtr);

    // Disabled: both pins pass through.
    p_disabled_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bits[0] |-> (rts_o == mcr_rts && dtr_o == mcr_dtr));

    // Writing zero at the register address clears every field.
    p_write_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_OFFSET && cfg_wdata == '0) |=> cfg_bits == 3'b000);
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_OFFSET(CFG_OFFSET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tx_busy   (tx_busy),
    .txq_empty (txq_empty),
    .mcr_rts   (mcr_rts),
    .mcr_dtr   (mcr_dtr),
    .rts_o     (rts_o),
    .dtr_o     (dtr_o),
    .cfg_bits  (cfg_q)
);

// File: tb/rs485_dir_ctrl_bench.sv
// Bench for rs485_dir_ctrl: a vector table, then directed reset and corner tests.
module rs485_dir_ctrl_bench;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] OFS = 8'h40;
    localparam int NV = 12;

    // Vector layout: cfg[8:6] busy[5] qempty[4] mcr_rts[3] mcr_dtr[2] exp_rts[1] exp_dtr[0]
    localparam logic [8:0] VEC [NV] = '{
        9'b000_10_10_10, 9'b000_01_01_01, 9'b011_11_00_10, 9'b011_01_11_01,
        9'b011_00_00_10, 9'b111_11_01_01, 9'b111_01_00_10, 9'b001_11_00_01,
        9'b001_01_11_10, 9'b101_10_11_10, 9'b101_01_00_01, 9'b110_10_01_01
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = OFS;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;
    logic tx_busy = 1'b1, txq_empty = 1'b0, mcr_rts = 1'b1, mcr_dtr = 1'b0;
    logic rts_o, dtr_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rs485_dir_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_OFFSET(OFS)) u_rs485_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tx_busy(tx_busy),
        .txq_empty(txq_empty), .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr),
        .rts_o(rts_o), .dtr_o(dtr_o)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive a write on the falling edge; it lands at the next rising edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = OFS;
    endtask

    task automatic drive(input logic b, input logic q, input logic r, input logic d);
        @(negedge clk);
        tx_busy = b; txq_empty = q; mcr_rts = r; mcr_dtr = d;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: during and after reset the pins pass through and register reads 0.
        repeat (3) @(posedge clk);
        #1;
        check("R1 rts", rts_o, 1);
        check("R1 dtr", dtr_o, 0);
        check("R1 rdata", cfg_rdata, 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 rts after", rts_o, 1);

        // Table walk covering R5, R6 and R7.
        for (int i = 0; i < NV; i++) begin
            string tag;
            wr(OFS, {5'b0, VEC[i][8:6]});
            drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            tag = !VEC[i][6] ? "R7" : (VEC[i][8] ? "R5" : "R6");
            check(tag, rts_o, int'(VEC[i][1]));
            check(tag, dtr_o, int'(VEC[i][0]));
        end

        // R2: upper bits dropped, other address ignored and reads 0.
        wr(OFS, 8'hFF);
        #1; check("R2 readback", cfg_rdata, 8'h07);
        wr(8'h41, 8'h00);
        #1; check("R2 other addr write", cfg_rdata, 8'h07);
        cfg_addr = 8'h41; #1;
        check("R2 other addr read", cfg_rdata, 0);
        cfg_addr = OFS;

        // R3: zero lead delay on RTS, active high.
        wr(OFS, 8'h03);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        check("R3 idle", rts_o, 0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check("R3 same cycle", rts_o, 1);

        // R4: inter-character gap holds, then drops at once when drained.
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 gap hold", rts_o, 1);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 drop", rts_o, 0);

        // R8: writing zero mid-transmission hands the pin back to its input.
        drive(1'b1, 1'b0, 1'b0, 1'b1);
        check("R8 before", rts_o, 1);
        wr(OFS, 8'h00);
        #1;
        check("R8 rts", rts_o, 0);
        check("R8 dtr", dtr_o, 1);
        check("R8 rdata", cfg_rdata, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule